// File: doc/BRIEF.md
# PCI Interrupt Link Router

This block sits between four level-sensitive PCI interrupt links and a bank of legacy interrupt-controller inputs. Each link has its own byte-wide routing register. The register either names the legacy input that the link drives or switches the link off. Software writes the routing registers through a byte-addressed configuration write port of up to four byte lanes.

Several links may be routed to the same input, and that input then shows the OR of those links. The block keeps a registered bitmap with one bit for each pair of output and link. The bitmap is rebuilt every cycle from the routing registers as they stand after the write in that cycle and from the live link levels. A level change or a routing rewrite therefore reaches the outputs one clock later.

A small combinational stage converts a device's slot number and INTx pin into the link index that carries its interrupt. A readback port reports the routing byte of one selected link and the input that link resolves to.

Top module: `pci_link_router`

## Requirements
- R1: During and after reset, every routing byte reads 8'h80 and every bit of `irq_out` is 0.
- R2: A routing byte with bit 7 set disables its link, whatever its low bits hold. With bit 7 clear, bits 3:0 select the legacy input index that the link drives.
- R3: A link whose selected index is NUM_OUT or higher drives no output, and its readback `rt_irq` is 5'h1F. When the link is disabled, `rt_irq` is also 5'h1F. Otherwise `rt_irq` is {1'b0, bits 3:0}.
- R4: Output k is 1 exactly when at least one enabled link selects k and has its level high. Links that share an output are ORed together.
- R5: `irq_out` is registered. A change on `link_lvl` shows on `irq_out` after the next rising clock edge and not before it.
- R6: After a routing write, the outputs follow the new routing at the next rising clock edge, rebuilt from the current levels of all four links. No output keeps a stale contribution from an old route.
- R7: Byte lane b of a write (data bits 8b+7:8b) targets the address `cfg_addr`+b, and only when `cfg_be[b]` is 1. The lane is taken only if that address is in 8'h60..8'h63, where 8'h60+n is the routing byte of link n (A=0 to D=3). All other lanes and addresses are ignored, and lanes may cross the window edges.
- R8: `swz_link` equals (swz_pin + swz_slot − 1) mod 4, where swz_pin 0..3 stands for INTA..INTD.
- R9: `rt_byte` shows the stored routing byte of the link selected by `rt_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte address of lane 0 |
| cfg_be | input | 4 | Byte-lane enables |
| cfg_wdata | input | 32 | Write data, lane b in bits 8b+7:8b |
| link_lvl | input | 4 | Live levels of links A..D (bit n = link n) |
| swz_slot | input | SLOT_W | Device slot number for the swizzle |
| swz_pin | input | 2 | Device INTx pin, 0 = INTA |
| swz_link | output | 2 | Link index carrying that pin |
| rt_sel | input | 2 | Link selected for readback |
| rt_byte | output | 8 | Routing byte of the selected link |
| rt_irq | output | 5 | Resolved input index, 5'h1F when none |
| irq_out | output | NUM_OUT | Legacy interrupt-controller inputs |

## Verification
The hardest case to reach from the ports is a routing rewrite made while links are already asserted. A correct design must drop the contribution at the old output and raise the new one in the same cycle. To force this, the bench sweeps every link across every output index while all four levels stay high, and it rewrites routes with a fixed, nonzero level pattern applied. Writes are also issued as unaligned multi-lane writes that cross both edges of the routing window. A second instance with twelve outputs makes selection values above the output range reachable.

// File: rtl/pci_link_router.sv
module pci_link_router #(
  parameter int NUM_OUT = 16,
  parameter int SLOT_W  = 5,
  parameter int BASE    = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  input  logic [3:0]         link_lvl,
  input  logic [SLOT_W-1:0]  swz_slot,
  input  logic [1:0]         swz_pin,
  output logic [1:0]         swz_link,
  input  logic [1:0]         rt_sel,
  output logic [7:0]         rt_byte,
  output logic [4:0]         rt_irq,
  output logic [NUM_OUT-1:0] irq_out
);
  localparam int NL    = 4;
  localparam int LANES = 4;
  localparam int MW    = NUM_OUT * NL;

  logic [7:0]    route_q [NL];
  logic [7:0]    route_d [NL];
  logic [MW-1:0] map_q, map_d;
  logic [8:0]    lane_a   [LANES];
  logic [1:0]    lane_off [LANES];
  logic [LANES-1:0] lane_hit;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_a[b]   = {1'b0, cfg_addr} + 9'(b);
    assign lane_hit[b] = cfg_we && cfg_be[b] &&
                         lane_a[b] >= 9'(BASE) && lane_a[b] < 9'(BASE + NL);
    assign lane_off[b] = 2'(lane_a[b] - 9'(BASE));
  end

  always_comb begin
    for (int l = 0; l < NL; l++) route_d[l] = route_q[l];
    for (int b = 0; b < LANES; b++)
      if (lane_hit[b]) route_d[lane_off[b]] = cfg_wdata[8*b +: 8];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    for (genvar l = 0; l < NL; l++) begin : g_link
      assign map_d[o*NL + l] = !route_d[l][7] && route_d[l][3:0] == 4'(o) && link_lvl[l];
    end
    assign irq_out[o] = |map_q[o*NL +: NL];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) route_q[l] <= 8'h80;
      map_q <= '0;
    end else begin
      for (int l = 0; l < NL; l++) route_q[l] <= route_d[l];
      map_q <= map_d;
    end
  end

  assign rt_byte  = route_q[rt_sel];
  assign rt_irq   = (rt_byte[7] || {1'b0, rt_byte[3:0]} >= 5'(NUM_OUT)) ? 5'h1F
                                                                        : {1'b0, rt_byte[3:0]};
  assign swz_link = 2'(swz_pin + swz_slot[1:0] + 2'd3);
endmodule

module pci_link_router_chk #(
  parameter int NUM_OUT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [3:0]         link_lvl,
  input logic [7:0]         rt_byte,
  input logic [4:0]         rt_irq,
  input logic [7:0]         route_q [4],
  input logic [NUM_OUT-1:0] irq_out
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> irq_out == '0);

  // R2
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[0][7] && route_q[1][7] && route_q[2][7] && route_q[3][7] && !cfg_we)
    |=> irq_out == '0);

  // R4
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> $past(|link_lvl));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cfg_we && !$past(cfg_we) && $stable(link_lvl)) |=> $stable(irq_out));

  // R3
  off_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_byte[7] |-> rt_irq == 5'h1F);
endmodule

bind pci_link_router pci_link_router_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .link_lvl(link_lvl),
  .rt_byte(rt_byte), .rt_irq(rt_irq), .route_q(route_q), .irq_out(irq_out)
);

// File: tb/test_pci_link_router.sv
module test_pci_link_router;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [3:0]  link_lvl = 0;
  logic [4:0]  swz_slot = 0;
  logic [1:0]  swz_pin = 0, rt_sel = 0;
  logic [1:0]  swz_link, swz_link_s;
  logic [7:0]  rt_byte, rt_byte_s;
  logic [4:0]  rt_irq, rt_irq_s;
  logic [15:0] irq_out;
  logic [11:0] irq_s;
  int checks = 0, errors = 0;
  logic [7:0] rb [4];

  always #4 clk = ~clk;

  pci_link_router i_pci_link_router (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_be, .cfg_wdata, .link_lvl,
    .swz_slot, .swz_pin, .swz_link, .rt_sel, .rt_byte, .rt_irq, .irq_out);

  pci_link_router #(.NUM_OUT(12)) i_pci_link_router_small (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_be, .cfg_wdata, .link_lvl,
    .swz_slot, .swz_pin, .swz_link(swz_link_s), .rt_sel, .rt_byte(rt_byte_s),
    .rt_irq(rt_irq_s), .irq_out(irq_s));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [3:0] lvl, input int n);
    logic [15:0] e = '0;
    for (int l = 0; l < 4; l++)
      if (!rb[l][7] && int'(rb[l][3:0]) < n && lvl[l]) e[rb[l][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic check_outs(input string req);
    logic [15:0] e = model(link_lvl, 16);
    logic [15:0] es = model(link_lvl, 12);
    chk(irq_out == e, req, irq_out, e);
    chk(irq_s == es[11:0], req, irq_s, es[11:0]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    for (int b = 0; b < 4; b++) begin
      int ad = int'(a) + b;
      if (be[b] && ad >= 'h60 && ad <= 'h63) rb[ad - 'h60] = d[8*b +: 8];
    end
    @(negedge clk);
    cfg_we = 0; cfg_be = 0;
  endtask

  task automatic check_rb(input string req);
    for (int l = 0; l < 4; l++) begin
      rt_sel = 2'(l);
      #1;
      chk(rt_byte == rb[l], req, rt_byte, rb[l]);
    end
  endtask

  task automatic set_lvl(input logic [3:0] v);
    logic [15:0] old = irq_out;
    @(negedge clk);
    link_lvl = v;
    #1;
    chk(irq_out == old, "R5 early", irq_out, old);
    @(negedge clk);
    check_outs("R4 R5");
  endtask

  initial begin
    for (int l = 0; l < 4; l++) rb[l] = 8'h80;
    link_lvl = 4'hF;
    repeat (3) @(negedge clk);
    chk(irq_out == 0, "R1 in reset", irq_out, 0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(irq_out == 0, "R1 R2 after reset", irq_out, 0);
    check_rb("R1");

    // R2 R6 R9: every link to every output with all levels high
    for (int l = 0; l < 4; l++) begin
      for (int q = 0; q < 16; q++) begin
        wr(8'(8'h60 + l), 4'b0001, 32'(q));
        check_outs("R6");
        rt_sel = 2'(l);
        #1;
        chk(rt_byte == 8'(q), "R9", rt_byte, q);
        chk(rt_irq == 5'(q), "R3 enabled report", rt_irq, q);
        chk(rt_irq_s == (q >= 12 ? 5'h1F : 5'(q)), "R3 small report", rt_irq_s, q);
      end
      wr(8'(8'h60 + l), 4'b0001, 32'h85);
      check_outs("R2 disabled");
      #1;
      chk(rt_irq == 5'h1F, "R3 disabled report", rt_irq, 5'h1F);
    end

    // R4 shared output, full level sweep
    wr(8'h60, 4'hF, 32'h05050505);
    for (int v = 0; v < 16; v++) set_lvl(4'(v));
    // R4 distinct outputs, incl. ones out of range for the small instance
    wr(8'h60, 4'hF, 32'h0E090703);
    for (int v = 0; v < 16; v++) set_lvl(4'(v ^ 5));

    // R6 rebuild under fixed levels
    set_lvl(4'b1010);
    wr(8'h61, 4'b0001, 32'h02);
    check_outs("R6 reroute");
    wr(8'h63, 4'b0001, 32'h02);
    check_outs("R6 share");
    wr(8'h61, 4'b0001, 32'h0D);
    check_outs("R6 move");

    // R7 lanes crossing window edges
    wr(8'h5F, 4'hF, 32'h0C0B0A99);
    check_rb("R7 low edge");
    check_outs("R7");
    wr(8'h62, 4'b0101, 32'h00440006);
    check_rb("R7 be mask");
    wr(8'h62, 4'b1110, 32'h11223344);
    check_rb("R7 high edge");
    wr(8'h64, 4'hF, 32'h01010101);
    check_rb("R7 outside");
    check_outs("R7 outside");
    wr(8'h60, 4'b0000, 32'h01010101);
    check_rb("R7 no lanes");

    // R8 swizzle exhaustive
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        swz_slot = 5'(s); swz_pin = 2'(p);
        #1;
        chk(swz_link == 2'((p + s + 3) % 4), "R8", swz_link, (p + s + 3) % 4);
      end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule